// File: doc/BRIEF.md
# Two-Way Loop Buffer Controller

This block sits beside the instruction supply path of a processor and keeps the decoded form of short loop bodies, so that later passes through a loop are served from local registers. While a loop is served this way, the block cancels the instruction RAM request and bypasses the decode logic. Addresses count fetch slots: each cycle one packet is fetched, and the packet after address `a` is `a+1`.

The block allocates storage only when a taken-branch target repeats the target of the previous unmatched taken branch. That target is held in a single candidate register. When this happens, the block claims the least recently used of its ways and records the decoded words of the loop as they arrive from decode, `DEC_LAT` cycles after their fetch slots. When a later taken branch lands on a stored loop start, the block cancels the RAM fetch and serves the stored entries one per slot. Each entry appears on the replay port at the decode-stage time, `DEC_LAT` cycles after its slot. When the stored count is used up, the block tells fetch where to resume.

The state machine has three states:
- `LB_IDLE`: normal fetch.
- `LB_FILL`: recording a loop.
- `LB_RUN`: serving a loop.

Transitions:
- Any state goes to `LB_RUN` on a branch that hits a way (the "hit" transition).
- Any state goes to `LB_FILL` on a branch that matches the candidate (the "allocate" transition).
- Any state goes to `LB_IDLE` on a branch that matches neither (the "miss" transition).
- `LB_RUN` goes to `LB_IDLE` when the stored count is used up (the "overrun" transition).
- Without a branch, `LB_FILL` and `LB_RUN` otherwise hold.

Top module: `loop_buffer`

## Requirements
- R1: After reset, `fetch_cancel`, `redirect_valid` and `replay_valid` are low. No way holds a loop, so the first taken branch is a miss, and the LRU pointer selects way 0.
- R2: A taken branch that hits no way and differs from the candidate is a miss. It loads its target into the candidate, enters `LB_IDLE` and does not cancel. A later taken branch to a target equal to the candidate allocates a way. A miss to a different target in between replaces the candidate, so the old target no longer allocates.
- R3: Allocation claims the least recently used way, loads its base with the target, invalidates its old contents, makes it most recently used and clears the candidate.
- R4: In `LB_FILL`, every fetch slot from the allocating slot up to the slot before the next taken branch is written to the next entry in order. The data stored for a slot is the `dec_word` value present `DEC_LAT` cycles after that slot.
- R5: Writing stops once `DEPTH` entries are written; further slots of the loop are not stored, and the stored count is capped at `DEPTH`.
- R6: A taken branch whose target equals the base of a valid way asserts `fetch_cancel` in that slot and in each following slot until the stored count of slots has been served. For the slot serving entry i, `replay_valid` is high `DEC_LAT` cycles later with entry i on `replay_word`; otherwise `replay_valid` is low.
- R7: In the slot after the last served entry (no branch), `redirect_valid` is high with `redirect_addr` = base + count, `fetch_cancel` is low, and the block returns to `LB_IDLE`.
- R8: A taken branch during `LB_RUN` goes through the full compare in that same slot. A hit on a way restarts serving from entry 0 of that way, and a miss ends serving.
- R9: A taken branch during `LB_FILL` records the number of entries written as that way's count and makes the way valid. The same-slot compare may already hit the just-filled way or another way.
- R10: A hit makes the hit way most recently used, so the next allocation evicts the other way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_taken | input | 1 | A taken branch redirects the fetch of this slot |
| br_target | input | ADDR_W | Target address of the taken branch |
| dec_word | input | WORD_W | Decoded word of the slot fetched DEC_LAT cycles earlier |
| fetch_cancel | output | 1 | Cancel this slot's instruction RAM request; the slot is served from the buffer |
| redirect_valid | output | 1 | Serving ended; fetch this slot from redirect_addr |
| redirect_addr | output | ADDR_W | Resume address, base plus stored count |
| replay_valid | output | 1 | replay_word carries a stored decoded word for the decode stage |
| replay_word | output | WORD_W | Replayed decoded word |

## Verification
The bench drives loops as branch patterns of chosen length and start address. It computes cancel, redirect and replay expectations per slot from the stored count, and derives each decoded word arithmetically from its slot address. While a slot is cancelled, the bench drives a garbage word on `dec_word`, so replayed data is shown to come from storage. Loops shorter than the depth, a loop longer than the depth (saturation and resume address), and branches that cut serving short separate the count, overrun and re-compare paths. Interleaving three to four loop starts separates true LRU replacement from fixed or non-updated victim choice, and separates candidate replacement from a sticky candidate.

// File: rtl/loop_buffer_pkg.sv
`timescale 1ns/1ps
package loop_buffer_pkg;
    typedef enum logic [1:0] {
        LB_IDLE = 2'd0,
        LB_FILL = 2'd1,
        LB_RUN  = 2'd2
    } lb_state_e;
endpackage

// File: rtl/lb_tags.sv
`timescale 1ns/1ps
// Per-way base/count/valid, candidate register and LRU pointer, plus compare.
module lb_tags #(
    parameter int AW    = 16,
    parameter int WAYS  = 2,
    parameter int DEPTH = 8,
    parameter int WW    = 1,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] br_target,
    input  logic          alloc_en,
    input  logic [WW-1:0] alloc_way,
    input  logic          close_en,
    input  logic [WW-1:0] close_way,
    input  logic [CW-1:0] close_cnt,
    input  logic          hit_en,
    input  logic          cand_load,
    input  logic [WW-1:0] sel_way,
    output logic          hit_any,
    output logic [WW-1:0] hit_way,
    output logic          cand_hit,
    output logic [WW-1:0] victim,
    output logic [AW-1:0] sel_base,
    output logic [CW-1:0] sel_cnt
);
    logic [AW-1:0]   base [WAYS];
    logic [CW-1:0]   cnt  [WAYS];
    logic [WAYS-1:0] vld;
    logic [WAYS-1:0] match;
    logic [AW-1:0]   cand;
    logic            cand_vld;
    logic            lru;

    // a way being closed this slot is already eligible for a hit
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = (vld[w] || (close_en && (close_way == WW'(w))))
                          && (base[w] == br_target);
    end

    always_comb begin
        hit_any = |match;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WW'(w);
        end
    end

    assign cand_hit = cand_vld && (cand == br_target);
    assign victim   = (WAYS > 1) ? WW'(lru) : '0;
    assign sel_base = base[sel_way];
    assign sel_cnt  = cnt[sel_way];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld      <= '0;
            cand     <= '0;
            cand_vld <= 1'b0;
            lru      <= 1'b0;
            for (int w = 0; w < WAYS; w++) begin
                base[w] <= '0;
                cnt[w]  <= '0;
            end
        end else begin
            if (close_en) begin
                vld[close_way] <= 1'b1;
                cnt[close_way] <= close_cnt;
            end
            if (alloc_en) begin
                vld[alloc_way]  <= 1'b0;
                base[alloc_way] <= br_target;
                cand_vld        <= 1'b0;
                lru             <= ~alloc_way[0];
            end
            if (hit_en) lru <= ~hit_way[0];
            if (cand_load) begin
                cand     <= br_target;
                cand_vld <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/lb_ctrl.sv
`timescale 1ns/1ps
// IDLE/FILL/RUN sequencer: issues fetch-side write and read commands.
module lb_ctrl
    import loop_buffer_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WW    = 1,
    parameter int CW    = 4,
    parameter int XW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          br_taken,
    input  logic          hit_any,
    input  logic [WW-1:0] hit_way,
    input  logic          cand_hit,
    input  logic [WW-1:0] victim,
    input  logic [CW-1:0] sel_cnt,
    output lb_state_e     state,
    output logic [CW-1:0] idx,
    output logic [WW-1:0] way_r,
    output logic          alloc_en,
    output logic          close_en,
    output logic          hit_en,
    output logic          cand_load,
    output logic          cancel,
    output logic          redirect,
    output logic          wr_en,
    output logic [WW-1:0] wr_way,
    output logic [XW-1:0] wr_idx,
    output logic          rd_en,
    output logic [WW-1:0] rd_way,
    output logic [XW-1:0] rd_idx
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    lb_state_e     st_n;
    logic [CW-1:0] idx_n;
    logic [WW-1:0] way_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LB_IDLE;
            idx   <= '0;
            way_r <= '0;
        end else begin
            state <= st_n;
            idx   <= idx_n;
            way_r <= way_n;
        end
    end

    always_comb begin
        st_n      = state;
        idx_n     = idx;
        way_n     = way_r;
        alloc_en  = 1'b0;
        hit_en    = 1'b0;
        cand_load = 1'b0;
        cancel    = 1'b0;
        redirect  = 1'b0;
        wr_en     = 1'b0;
        wr_way    = way_r;
        wr_idx    = idx[XW-1:0];
        rd_en     = 1'b0;
        rd_way    = way_r;
        rd_idx    = idx[XW-1:0];
        close_en  = (state == LB_FILL) && br_taken;
        if (br_taken) begin
            if (hit_any) begin
                hit_en = 1'b1;
                cancel = 1'b1;
                rd_en  = 1'b1;
                rd_way = hit_way;
                rd_idx = '0;
                st_n   = LB_RUN;
                idx_n  = CW'(1);
                way_n  = hit_way;
            end else if (cand_hit) begin
                alloc_en = 1'b1;
                wr_en    = 1'b1;
                wr_way   = victim;
                wr_idx   = '0;
                st_n     = LB_FILL;
                idx_n    = CW'(1);
                way_n    = victim;
            end else begin
                cand_load = 1'b1;
                st_n      = LB_IDLE;
                idx_n     = '0;
            end
        end else begin
            unique case (state)
                LB_IDLE: begin
                    st_n = LB_IDLE;
                end
                LB_FILL: begin
                    if (idx < DEPTH_C) begin
                        wr_en = 1'b1;
                        idx_n = idx + CW'(1);
                    end
                end
                LB_RUN: begin
                    if (idx < sel_cnt) begin
                        cancel = 1'b1;
                        rd_en  = 1'b1;
                        idx_n  = idx + CW'(1);
                    end else begin
                        redirect = 1'b1;
                        st_n     = LB_IDLE;
                        idx_n    = '0;
                    end
                end
                default: begin
                    st_n  = LB_IDLE;
                    idx_n = '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/lb_store.sv
`timescale 1ns/1ps
// Decoded-word storage; commands are delayed to the decode stage.
module lb_store #(
    parameter int DW    = 32,
    parameter int WAYS  = 2,
    parameter int DEPTH = 8,
    parameter int LAT   = 2,
    parameter int WW    = 1,
    parameter int XW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [WW-1:0] wr_way,
    input  logic [XW-1:0] wr_idx,
    input  logic          rd_en,
    input  logic [WW-1:0] rd_way,
    input  logic [XW-1:0] rd_idx,
    input  logic [DW-1:0] dec_word,
    output logic          replay_valid,
    output logic [DW-1:0] replay_word
);
    logic [DW-1:0]  mem [WAYS][DEPTH];
    logic [LAT-1:0] wv;
    logic [LAT-1:0] rv;
    logic [WW-1:0]  wwy [LAT];
    logic [XW-1:0]  wix [LAT];
    logic [WW-1:0]  rwy [LAT];
    logic [XW-1:0]  rix [LAT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wv <= '0;
            rv <= '0;
            for (int i = 0; i < LAT; i++) begin
                wwy[i] <= '0;
                wix[i] <= '0;
                rwy[i] <= '0;
                rix[i] <= '0;
            end
        end else begin
            wv[0]  <= wr_en;
            wwy[0] <= wr_way;
            wix[0] <= wr_idx;
            rv[0]  <= rd_en;
            rwy[0] <= rd_way;
            rix[0] <= rd_idx;
            for (int i = 1; i < LAT; i++) begin
                wv[i]  <= wv[i-1];
                wwy[i] <= wwy[i-1];
                wix[i] <= wix[i-1];
                rv[i]  <= rv[i-1];
                rwy[i] <= rwy[i-1];
                rix[i] <= rix[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wv[LAT-1]) mem[wwy[LAT-1]][wix[LAT-1]] <= dec_word;
    end

    assign replay_valid = rv[LAT-1];
    assign replay_word  = rv[LAT-1] ? mem[rwy[LAT-1]][rix[LAT-1]] : '0;
endmodule

// File: rtl/loop_buffer.sv
`timescale 1ns/1ps
module loop_buffer
    import loop_buffer_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int WORD_W  = 32,
    parameter int DEPTH   = 8,
    parameter int WAYS    = 2,
    parameter int DEC_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_taken,
    input  logic [ADDR_W-1:0] br_target,
    input  logic [WORD_W-1:0] dec_word,
    output logic              fetch_cancel,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_addr,
    output logic              replay_valid,
    output logic [WORD_W-1:0] replay_word
);
    localparam int WW = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam int XW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    lb_state_e   st;
    logic [CW-1:0] idx;
    logic [WW-1:0] way_r, hit_way, victim, wr_way, rd_way;
    logic [XW-1:0] wr_idx, rd_idx;
    logic          hit_any, cand_hit, alloc_en, close_en, hit_en, cand_load;
    logic          wr_en, rd_en, redirect;
    logic [ADDR_W-1:0] sel_base;
    logic [CW-1:0]     sel_cnt;

    lb_tags #(.AW(ADDR_W), .WAYS(WAYS), .DEPTH(DEPTH), .WW(WW), .CW(CW)) tags_i (
        .clk(clk), .rst_n(rst_n), .br_target(br_target),
        .alloc_en(alloc_en), .alloc_way(victim),
        .close_en(close_en), .close_way(way_r), .close_cnt(idx),
        .hit_en(hit_en), .cand_load(cand_load), .sel_way(way_r),
        .hit_any(hit_any), .hit_way(hit_way), .cand_hit(cand_hit),
        .victim(victim), .sel_base(sel_base), .sel_cnt(sel_cnt)
    );

    lb_ctrl #(.DEPTH(DEPTH), .WW(WW), .CW(CW), .XW(XW)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .br_taken(br_taken),
        .hit_any(hit_any), .hit_way(hit_way), .cand_hit(cand_hit),
        .victim(victim), .sel_cnt(sel_cnt),
        .state(st), .idx(idx), .way_r(way_r),
        .alloc_en(alloc_en), .close_en(close_en), .hit_en(hit_en),
        .cand_load(cand_load), .cancel(fetch_cancel), .redirect(redirect),
        .wr_en(wr_en), .wr_way(wr_way), .wr_idx(wr_idx),
        .rd_en(rd_en), .rd_way(rd_way), .rd_idx(rd_idx)
    );

    lb_store #(.DW(WORD_W), .WAYS(WAYS), .DEPTH(DEPTH), .LAT(DEC_LAT),
               .WW(WW), .XW(XW)) store_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_way(wr_way), .wr_idx(wr_idx),
        .rd_en(rd_en), .rd_way(rd_way), .rd_idx(rd_idx),
        .dec_word(dec_word),
        .replay_valid(replay_valid), .replay_word(replay_word)
    );

    assign redirect_valid = redirect;
    assign redirect_addr  = redirect ? (sel_base + ADDR_W'(sel_cnt)) : '0;
endmodule

// File: rtl/loop_buffer_chk.sv
`timescale 1ns/1ps
module loop_buffer_chk
    import loop_buffer_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          br_taken,
    input lb_state_e     st,
    input logic          hit_any,
    input logic          cand_hit,
    input logic [CW-1:0] idx,
    input logic          fetch_cancel,
    input logic          redirect_valid
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LB_IDLE && !br_taken) |-> (!fetch_cancel && !redirect_valid));

    a_r2_alloc_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken && !hit_any && cand_hit) |=> (st == LB_FILL));

    a_r2_miss_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken && !hit_any && !cand_hit) |=> (st == LB_IDLE));

    a_r4_fill_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LB_FILL && !br_taken) |=> (st == LB_FILL));

    a_r5_idx_cap: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= CW'(DEPTH));

    a_r6_hit_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken && hit_any) |-> fetch_cancel);

    a_r6_hit_run: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken && hit_any) |=> (st == LB_RUN));

    a_r7_redirect_idle: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> (st == LB_IDLE));

    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_cancel && redirect_valid));
endmodule

bind loop_buffer loop_buffer_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
    .clk(clk), .rst_n(rst_n), .br_taken(br_taken), .st(st),
    .hit_any(hit_any), .cand_hit(cand_hit), .idx(idx),
    .fetch_cancel(fetch_cancel), .redirect_valid(redirect_valid)
);

// File: tb/loop_buffer_tb.sv
`timescale 1ns/1ps
module loop_buffer_tb_top;
    localparam int AW  = 16;
    localparam int DW  = 32;
    localparam int DEP = 8;
    localparam int LAT = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          br_taken = 1'b0;
    logic [AW-1:0] br_target = '0;
    logic [DW-1:0] dec_word = '0;
    logic          fetch_cancel, redirect_valid, replay_valid;
    logic [AW-1:0] redirect_addr;
    logic [DW-1:0] replay_word;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic          ev [16];
    logic [DW-1:0] ew [16];
    logic          hv [16];
    logic          hc [16];
    logic [AW-1:0] ha [16];

    always #5 clk = ~clk;

    loop_buffer #(.ADDR_W(AW), .WORD_W(DW), .DEPTH(DEP), .WAYS(2), .DEC_LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .br_taken(br_taken), .br_target(br_target),
        .dec_word(dec_word), .fetch_cancel(fetch_cancel),
        .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
        .replay_valid(replay_valid), .replay_word(replay_word)
    );

    function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
        return {a, ~a};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s cycle %0d: got %h expected %h", tag, what, cyc, got, exp);
        end
    endtask

    // one fetch slot; exp_c: slot served from buffer, exp_r: resume slot
    task automatic slot(input bit br, input logic [AW-1:0] addr,
                        input bit exp_c, input bit exp_r, input string tag);
        int p;
        @(posedge clk);
        #1;
        cyc++;
        br_taken  = br;
        br_target = addr;
        p = (cyc - LAT) % 16;
        if (cyc > LAT && hv[p] && !hc[p]) dec_word = word_of(ha[p]);
        else dec_word = 32'hDEAD_BEEF;
        hv[cyc % 16] = 1'b1;
        hc[cyc % 16] = exp_c;
        ha[cyc % 16] = addr;
        ev[(cyc + LAT) % 16] = exp_c;
        ew[(cyc + LAT) % 16] = word_of(addr);
        @(negedge clk);
        chk(fetch_cancel == exp_c, tag, "fetch_cancel", DW'(fetch_cancel), DW'(exp_c));
        chk(redirect_valid == exp_r && (!exp_r || redirect_addr == addr), tag,
            "redirect", {redirect_addr, 15'd0, redirect_valid}, {addr, 15'd0, exp_r});
        chk(replay_valid == ev[cyc % 16], tag, "replay_valid",
            DW'(replay_valid), DW'(ev[cyc % 16]));
        if (ev[cyc % 16])
            chk(replay_word == ew[cyc % 16], tag, "replay_word", replay_word, ew[cyc % 16]);
        ev[cyc % 16] = 1'b0;
    endtask

    // one pass of a loop at base b with len slots; hit with stored count cnt
    task automatic pass(input logic [AW-1:0] b, input int len, input bit hit,
                        input int cnt, input string tag);
        for (int s = 0; s < len; s++)
            slot(s == 0, b + AW'(s), hit && (s < cnt), hit && (s == cnt), tag);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            ev[i] = 1'b0; ew[i] = '0; hv[i] = 1'b0; hc[i] = 1'b0; ha[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!fetch_cancel, "R1", "reset cancel", DW'(fetch_cancel), 0);
        chk(!redirect_valid, "R1", "reset redirect", DW'(redirect_valid), 0);
        chk(!replay_valid, "R1", "reset replay", DW'(replay_valid), 0);

        pass(16'h0100, 5, 0, 0, "R1");   // first branch misses
        pass(16'h0100, 5, 0, 0, "R4");   // allocate way0, fill 5
        pass(16'h0100, 5, 1, 5, "R9");   // close fill, same-slot hit
        pass(16'h0100, 5, 1, 5, "R6");
        pass(16'h0200, 12, 0, 0, "R8");  // miss out of RUN
        pass(16'h0200, 12, 0, 0, "R5");  // allocate way1, saturate
        pass(16'h0200, 12, 1, 8, "R7");  // serve 8, resume at 0x208
        pass(16'h0100, 5, 1, 5, "R6");
        pass(16'h0100, 2, 1, 5, "R8");   // cut short by branch
        pass(16'h0300, 3, 0, 0, "R8");   // miss ends serving
        pass(16'h0300, 3, 0, 0, "R3");   // allocate LRU way1
        pass(16'h0300, 3, 1, 3, "R9");
        pass(16'h0200, 12, 0, 0, "R10"); // evicted
        pass(16'h0100, 5, 1, 5, "R10");  // kept
        pass(16'h0100, 2, 1, 5, "R8");
        pass(16'h0300, 3, 1, 3, "R8");   // hit on other way from RUN
        pass(16'h0400, 4, 0, 0, "R2");
        pass(16'h0400, 4, 0, 0, "R3");   // allocate way0
        pass(16'h0300, 3, 1, 3, "R9");   // close fill, hit other way
        pass(16'h0400, 4, 1, 4, "R9");
        pass(16'h0100, 5, 0, 0, "R10");  // evicted
        pass(16'h0600, 2, 0, 0, "R2");
        pass(16'h0500, 2, 0, 0, "R2");   // candidate replaced
        pass(16'h0600, 2, 0, 0, "R2");   // not an allocation
        pass(16'h0600, 2, 0, 0, "R2");   // allocation
        pass(16'h0600, 5, 1, 2, "R7");
        br_taken = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule